// File: doc/BRIEF.md
# Serial Memory Slave Bus Controller

This block is the bus side of a 256-byte serial memory that answers as a slave on a two-wire I2C bus. The raw clock and data lines are passed through synchronisers into a fast system clock, and all bus events are found by sampling them there. The block drives the data line only through an open-drain enable: when the enable is high, the line is pulled low. It finds start and stop conditions and checks the address byte against a fixed type code and three strap inputs. It acknowledges bytes and keeps one word pointer that reads and writes share. Reads are served from an asynchronous 256x8 array read port. Bytes received for writing are handed to a separate page-write unit together with their target address, and a commit pulse tells that unit when to start programming.

A master writes by sending a write-mode address, a word address and data bytes, then a stop. A master reads by sending a read-mode address, which starts at the current pointer, or by sending a write-mode address and a word address first, then a repeated start and a read-mode address. While the page-write unit reports busy, the block stays silent on its own address. The master can therefore keep retrying the address until it is acknowledged.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: An address byte selects the device only when its upper seven bits equal type code 1010 followed by dev_sel[2:0] (MSB first), and bit 0 selects the direction: 1 = read, 0 = write. Any other type code is not acknowledged.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start in any state, including in the middle of a byte, drops the transfer, releases SDA and begins receiving a new address byte. After reset, sda_oe, wr_valid and wr_commit are low.
- R3: An acknowledge holds sda_oe high from the SCL fall that ends the 8th bit to the SCL fall that ends the 9th bit. After that, sda_oe is low unless read data is being sent.
- R4: If the address does not match, no acknowledge and no drive are given for any byte until the next start.
- R5: After a write-mode address, the first byte loads the word pointer. Each following byte is acknowledged and produces a one-cycle wr_valid carrying wr_addr (the pointer) and wr_data (the byte). The pointer then advances within its 16-byte page, so the low 4 bits wrap from F to 0 and the upper bits are kept.
- R6: A stop that ends a write carrying at least one data byte gives exactly one wr_commit pulse, one cycle after the stop is detected. A stop after only an address, or after an address and a word address, gives none.
- R7: A write-mode address plus a word address, then a repeated start and a read-mode address, returns data from the newly loaded word address.
- R8: Read data is sent MSB first, with each new bit driven after an SCL fall. A master acknowledge (SDA low in the 9th clock) starts the next byte. A master no-acknowledge makes the block release SDA until the next start or stop.
- R9: During reads the pointer advances by one across all 8 bits after each byte sent, so it wraps from 0xFF to 0x00.
- R10: A read-mode address with no word address returns the byte at the pointer left by the last access: the last byte read plus one, or the page-wrapped next address after a write.
- R11: While busy_i is high, the block does not acknowledge even a matching address.
- R12: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| dev_sel | input | 3 | Strapped device select bits |
| busy_i | input | 1 | Page-write unit is programming |
| mem_raddr | output | 8 | Array read address (word pointer) |
| mem_rdata | input | 8 | Array read data for mem_raddr |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 8 | Target address of the write byte |
| wr_data | output | 8 | Received write byte |
| wr_commit | output | 1 | One-cycle pulse: start programming the buffered bytes |

## Verification
Several address patterns are driven on the bus: a matching address, a wrong strap field, a wrong type code, and a matching address while busy. Together they separate the address compare from the busy gate. Reads are tried as current-address, random and sequential. The sequential read starts at 0xFE, which shows that the read pointer wraps across all 8 bits. A three-byte page write starting at 0x3E shows that write addresses wrap only within the 16-byte page, and a following current-address read shows where the pointer was left. A start forced after four bits of a byte, and extra clocks after a read no-acknowledge, check that a transfer can be dropped and that the line is released.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int EE_AW = 8;
  localparam logic [3:0] EE_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK, ST_WA, ST_WD, ST_RD, ST_RACK, ST_RGO, ST_IGN
  } ee_st_t;

  // Device selected when the type nibble and the strap field both agree.
  function automatic logic addr_match(input logic [7:0] b, input logic [2:0] strap);
    return b[7:1] == {EE_TYPE, strap};
  endfunction

  // Next write address: low plog bits wrap, the page bits are kept.
  function automatic logic [EE_AW-1:0] page_next(input logic [EE_AW-1:0] a,
                                                 input int unsigned plog);
    logic [EE_AW-1:0] m;
    m = EE_AW'((1 << plog) - 1);
    return (a & ~m) | ((a + EE_AW'(1)) & m);
  endfunction

  // Next read address: full-width increment.
  function automatic logic [EE_AW-1:0] lin_next(input logic [EE_AW-1:0] a);
    return a + EE_AW'(1);
  endfunction
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int PAGE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [2:0]       dev_sel,
  input  logic             busy_i,
  input  logic [EE_AW-1:0] mem_rdata,
  output logic [EE_AW-1:0] mem_raddr,
  output logic             sda_oe,
  output logic             wr_valid,
  output logic [EE_AW-1:0] wr_addr,
  output logic [EE_AW-1:0] wr_data,
  output logic             wr_commit,
  output logic             dev_ack_on,
  output logic             ign_on
);
  localparam int CW = 4;

  ee_st_t           st, ack_nxt;
  logic [CW-1:0]    cnt;
  logic [7:0]       rx, tx;
  logic [EE_AW-1:0] ptr;
  logic             ack_drv, tx_drv, wr_seen;
  logic [7:0]       rx_byte;
  logic             rx_state;

  assign rx_byte  = {rx[6:0], sda_s};
  assign rx_state = (st == ST_DEV) || (st == ST_WA) || (st == ST_WD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ack_nxt   <= ST_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      ack_drv   <= 1'b0;
      tx_drv    <= 1'b0;
      wr_seen   <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_evt) begin
        st      <= ST_DEV;
        cnt     <= '0;
        ack_drv <= 1'b0;
        tx_drv  <= 1'b0;
        wr_seen <= 1'b0;
      end else if (stop_evt) begin
        st        <= ST_IDLE;
        ack_drv   <= 1'b0;
        tx_drv    <= 1'b0;
        wr_commit <= wr_seen;
        wr_seen   <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise) begin
          rx  <= rx_byte;
          cnt <= cnt + CW'(1);
          if (cnt == CW'(7)) begin
            unique case (st)
              ST_DEV: begin
                if (addr_match(rx_byte, dev_sel) && !busy_i) begin
                  st      <= ST_ACK;
                  ack_nxt <= rx_byte[0] ? ST_RD : ST_WA;
                end else begin
                  st <= ST_IGN;
                end
              end
              ST_WA: begin
                ptr     <= rx_byte;
                st      <= ST_ACK;
                ack_nxt <= ST_WD;
              end
              default: begin
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= rx_byte;
                ptr      <= page_next(ptr, PAGE_LOG2);
                wr_seen  <= 1'b1;
                st       <= ST_ACK;
                ack_nxt  <= ST_WD;
              end
            endcase
          end
        end
      end else begin
        unique case (st)
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_drv) begin
                ack_drv <= 1'b1;
              end else begin
                ack_drv <= 1'b0;
                cnt     <= '0;
                st      <= ack_nxt;
                if (ack_nxt == ST_RD) begin
                  tx     <= mem_rdata;
                  tx_drv <= ~mem_rdata[7];
                end
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + CW'(1);
            end else if (scl_fall) begin
              if (cnt == CW'(8)) begin
                tx_drv <= 1'b0;
                ptr    <= lin_next(ptr);
                st     <= ST_RACK;
              end else begin
                tx_drv <= ~tx[3'(CW'(7) - cnt)];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) st <= sda_s ? ST_IGN : ST_RGO;
          end
          ST_RGO: begin
            if (scl_fall) begin
              tx     <= mem_rdata;
              tx_drv <= ~mem_rdata[7];
              cnt    <= '0;
              st     <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_raddr  = ptr;
  assign sda_oe     = ack_drv | tx_drv;
  assign dev_ack_on = ack_drv && (st == ST_ACK) &&
                      ((ack_nxt == ST_WA) || (ack_nxt == ST_RD));
  assign ign_on     = (st == ST_IGN);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_LOG2   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       dev_sel,
  input  logic             busy_i,
  output logic [EE_AW-1:0] mem_raddr,
  input  logic [EE_AW-1:0] mem_rdata,
  output logic             wr_valid,
  output logic [EE_AW-1:0] wr_addr,
  output logic [EE_AW-1:0] wr_data,
  output logic             wr_commit
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic dev_ack_on, ign_on;

  i2c_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_ee_ctrl #(.PAGE_LOG2(PAGE_LOG2)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .dev_sel    (dev_sel),
    .busy_i     (busy_i),
    .mem_rdata  (mem_rdata),
    .mem_raddr  (mem_raddr),
    .sda_oe     (sda_oe),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_commit  (wr_commit),
    .dev_ack_on (dev_ack_on),
    .ign_on     (ign_on)
  );
endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic wr_valid,
  input logic wr_commit,
  input logic busy_i,
  input logic dev_ack_on,
  input logic ign_on
);
  // R12
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R2
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R6
  commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R11
  busy_noack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ack_on) |-> !busy_i);

  // R4
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ign_on |-> !sda_oe);
endmodule

bind i2c_eeprom_slave i2c_ee_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_oe     (sda_oe),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .wr_valid   (wr_valid),
  .wr_commit  (wr_commit),
  .busy_i     (busy_i),
  .dev_ack_on (dev_ack_on),
  .ign_on     (ign_on)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int Q = 8;
  localparam int BUSY_CYC = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b1010, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy_i, wr_valid, wr_commit;
  logic [7:0] mem_raddr, mem_rdata, wr_addr, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(STRAP), .busy_i(busy_i), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  int total = 0, bad = 0;
  int clk_viol = 0, commits = 0, exp_commits = 0;
  logic [7:0] mem [256];
  logic [7:0] gold [256];
  logic [15:0] pend [$];
  logic [15:0] exp_wq [$];
  int busy_cnt = 0;
  int ptr = 0;

  assign busy_i = (busy_cnt != 0);
  assign mem_rdata = mem[mem_raddr];

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Page-write unit model: buffers strobed bytes, programs on commit.
  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
    if (rst_n && wr_valid) pend.push_back({wr_addr, wr_data});
    if (rst_n && wr_commit) begin
      while (pend.size() != 0) begin
        logic [15:0] e;
        e = pend.pop_front();
        mem[e[15:8]] = e[7:0];
      end
      busy_cnt = BUSY_CYC;
    end
  end

  // Per-clock comparison against the reference expectations.
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m && prev_scl && (sda_oe != prev_oe)) clk_viol++;
      if (wr_valid) begin
        if (exp_wq.size() == 0) chk("R5 unexpected write", {wr_addr, wr_data}, 0);
        else chk("R5 write addr/data", {wr_addr, wr_data}, exp_wq.pop_front());
      end
      if (wr_commit) commits++;
    end
    prev_scl = scl_m;
    prev_oe = sda_oe;
  end

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask
  task automatic do_start();
    sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half();
  endtask
  task automatic do_stop();
    sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half();
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; half(); scl_m = 1; half(); half(); scl_m = 0; half();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1; half(); scl_m = 1; half();
    ack = (sda_line == 1'b0);
    half(); scl_m = 0; half();
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      half(); scl_m = 1; half(); d = {d[6:0], sda_line}; half(); scl_m = 0;
    end
    half(); sda_m = mack ? 1'b0 : 1'b1; half(); scl_m = 1; half(); half();
    scl_m = 0; half(); sda_m = 1;
  endtask
  task automatic poll_ready(output logic got);
    logic a;
    got = 0;
    for (int t = 0; t < 40 && !got; t++) begin
      do_start(); send_byte({DEV, 1'b0}, a); do_stop();
      got = a;
    end
  endtask
  task automatic rd_check(input string req, input logic mack);
    logic [7:0] d;
    recv_byte(mack, d);
    chk(req, d, gold[ptr]);
    ptr = (ptr + 1) % 256;
  endtask
  task automatic set_ptr(input int a);
    logic k;
    do_start(); send_byte({DEV, 1'b0}, k); chk("R7 dummy-write address ack", k, 1);
    send_byte(8'(a), k); chk("R5 word address ack", k, 1);
    ptr = a;
  endtask

  initial begin
    logic a, got;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 13 + 7);
      gold[i] = 8'(i * 13 + 7);
    end
    repeat (5) @(negedge clk);
    chk("R2 reset sda_oe", sda_oe, 0);
    chk("R2 reset wr_valid", wr_valid, 0);
    chk("R2 reset wr_commit", wr_commit, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R4: strap mismatch, later byte ignored too
    do_start(); send_byte({4'b1010, 3'b011, 1'b0}, a); chk("R4 wrong strap no ack", a, 0);
    send_byte(8'h55, a); chk("R4 following byte ignored", a, 0);
    do_stop();
    // R1: wrong type code
    do_start(); send_byte({4'b1011, STRAP, 1'b0}, a); chk("R1 wrong type no ack", a, 0);
    do_stop();

    // R5 R3 R6: byte write
    do_start(); send_byte({DEV, 1'b0}, a); chk("R1 matching address ack", a, 1);
    half(); chk("R3 released after ack", sda_oe, 0);
    send_byte(8'h20, a); chk("R3 word ack", a, 1);
    exp_wq.push_back({8'h20, 8'hA5});
    send_byte(8'hA5, a); chk("R3 data ack", a, 1);
    exp_commits++; do_stop();
    gold[8'h20] = 8'hA5; ptr = 8'h21;
    repeat (4) @(negedge clk);
    chk("R6 commit after data write", commits, exp_commits);

    // R11: busy refusal and polling
    do_start(); send_byte({DEV, 1'b0}, a); chk("R11 no ack while busy", a, 0);
    do_stop();
    poll_ready(got); chk("R11 ack after busy ends", got, 1);
    repeat (4) @(negedge clk);
    chk("R6 no commit without data", commits, exp_commits);

    // R10: current-address read after a write
    do_start(); send_byte({DEV, 1'b1}, a); chk("R10 read address ack", a, 1);
    rd_check("R10 current read after write", 1'b0); do_stop();

    // R7: random read
    set_ptr(8'h20); do_start(); send_byte({DEV, 1'b1}, a);
    rd_check("R7 random read", 1'b0); do_stop();

    // R9 R8: sequential wrap, then NACK release
    set_ptr(8'hFE); do_start(); send_byte({DEV, 1'b1}, a);
    rd_check("R9 seq FE", 1'b1); rd_check("R9 seq FF", 1'b1);
    rd_check("R9 seq 00 after wrap", 1'b1); rd_check("R8 last byte", 1'b0);
    half(); scl_m = 1; half(); chk("R8 released after nack", sda_line, 1);
    half(); scl_m = 0; half();
    do_stop();

    // R5: page wrap on write, then R10 current read
    do_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h3E, a);
    exp_wq.push_back({8'h3E, 8'h11}); send_byte(8'h11, a);
    exp_wq.push_back({8'h3F, 8'h22}); send_byte(8'h22, a);
    exp_wq.push_back({8'h30, 8'h33}); send_byte(8'h33, a); chk("R5 third data ack", a, 1);
    exp_commits++; do_stop();
    gold[8'h3E] = 8'h11; gold[8'h3F] = 8'h22; gold[8'h30] = 8'h33; ptr = 8'h31;
    poll_ready(got); chk("R11 poll after page write", got, 1);
    do_start(); send_byte({DEV, 1'b1}, a);
    rd_check("R10 current read after page wrap", 1'b0); do_stop();
    set_ptr(8'h30); do_start(); send_byte({DEV, 1'b1}, a);
    rd_check("R5 wrapped byte programmed", 1'b0); do_stop();

    // R2: start in mid-byte aborts
    do_start(); bit_out(1); bit_out(0); bit_out(1); bit_out(1);
    do_start(); send_byte({DEV, 1'b1}, a); chk("R2 ack after mid-byte start", a, 1);
    rd_check("R2 read after abort", 1'b0); do_stop();

    repeat (10) @(negedge clk);
    chk("R12 sda_oe stable while SCL high", clk_viol, 0);
    chk("R5 all expected writes seen", exp_wq.size(), 0);
    chk("R6 total commits", commits, exp_commits);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule